// File: doc/BRIEF.md
# Bit-Field and Half-Immediate Datapath Unit

This unit performs the field and constant-building operations of an integer pipeline on 32-bit words in a single operation each. It can place a slice of a source word into a destination, clear a slice, pull a slice out right-justified with sign or zero fill, mirror a word end to end, load a 16-bit constant zero-extended, or load a 16-bit constant into the upper half while keeping the lower half. These single operations stand in for the usual mask, shift and OR sequences, and two constant moves build a full 32-bit constant without a literal pool.

Each request presents an operation code, the destination's present value, a source value, a 16-bit immediate, a starting bit position and a field width. The unit registers the outcome, so the result and its valid strobe appear on the clock edge after the request. A field request whose span does not fit in the word is not carried out: the destination value is returned and an error strobe is raised beside the result. Condition flags and register file access belong to the surrounding pipeline.

Top module: `bitfield_alu`

## Requirements
- R1: After reset `outValid`, `rangeErr` and `result` are all zero.
- R2: A request sampled with `inValid` high on a rising edge shows `outValid` high after that edge. An edge with `inValid` low drives `outValid` low and leaves `result` and `rangeErr` unchanged.
- R3: Operation code 5 (low constant) returns the 16-bit immediate in bits 15..0 with bits 31..16 zero.
- R4: Operation code 6 (high constant) returns the immediate in bits 31..16 and the destination's bits 15..0 in bits 15..0.
- R5: Operation code 0 (insert) returns the destination with bits lsb to lsb+width-1 replaced by source bits 0 to width-1. The result equals (destination AND NOT fieldMask) OR ((source shifted left by lsb) AND fieldMask).
- R6: Operation code 1 (clear) returns the destination with bits lsb to lsb+width-1 zeroed and all other bits kept.
- R7: Operation code 2 (signed extract) returns source bits lsb to lsb+width-1 in result bits 0 to width-1, with the upper bits copied from source bit lsb+width-1.
- R8: Operation code 3 (unsigned extract) returns the same slice right-justified with the upper bits zero.
- R9: Operation code 4 (reverse) returns the source with bit k moved to bit 31-k.
- R10: For codes 0 to 3 the field is legal when the width is 1 to 32 and lsb+width is at most 32. A width of 32 with lsb 0 is legal. Any other field request returns the destination unchanged and sets `rangeErr` to 1. Every legal request returns `rangeErr` 0.
- R11: Code 7 is reserved and returns the destination unchanged with `rangeErr` 0. Codes 4 to 7 ignore `lsbPos` and `fieldWidth` and never raise `rangeErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request present this cycle |
| opCode | input | 3 | Operation select (0 to 7) |
| dstVal | input | 32 | Current destination value |
| srcVal | input | 32 | Source operand |
| immVal | input | 16 | Immediate for the constant moves |
| lsbPos | input | 5 | Lowest bit of the field |
| fieldWidth | input | 6 | Field width in bits |
| outValid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered result |
| rangeErr | output | 1 | Field did not fit; destination returned |

## Verification
The bench aims at the ends of the field range. It uses a width of 32 at lsb 0, a one-bit field at bit 31, and a field whose top bit lands exactly on bit 31. A mask generator that overflows at full width would return zero or keep destination bits in these cases. It also uses spans of 33 and width zero, where a missing range check would corrupt the destination instead of returning it with the error raised. Signed extraction is run with the field's top bit both set and clear, which exposes sign fill taken from the wrong bit. The high-constant move and the reserved code are checked to keep the destination bits they must leave alone. Idle cycles are checked to hold the last result.

// File: rtl/bfa_pkg.sv
package bfa_pkg;

  typedef enum logic [2:0] {
    OP_INS   = 3'd0,
    OP_CLR   = 3'd1,
    OP_SEXT  = 3'd2,
    OP_UEXT  = 3'd3,
    OP_REV   = 3'd4,
    OP_MOVLO = 3'd5,
    OP_MOVHI = 3'd6,
    OP_RSVD  = 3'd7
  } opKind_e;

  // Strobes from control to datapath; exactly one path select is high per request.
  typedef struct packed {
    logic load;
    logic selIns;
    logic selClr;
    logic selSext;
    logic selUext;
    logic selRev;
    logic selLo;
    logic selHi;
    logic passDst;
    logic rangeBad;
  } strobes_t;

endpackage

// File: rtl/bfa_ctrl.sv
module bfa_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [2:0]                   opCode,
  input  logic [$clog2(DATA_W)-1:0]    lsbPos,
  input  logic [$clog2(DATA_W):0]      fieldWidth,
  output bfa_pkg::strobes_t            ctl
);
  import bfa_pkg::*;

  localparam int POS_W = $clog2(DATA_W);
  localparam int WID_W = POS_W + 1;
  localparam int SUM_W = WID_W + 1;

  opKind_e          opK;
  logic             fieldOp;
  logic [SUM_W-1:0] spanEnd;
  logic             badSpan;

  assign opK     = opKind_e'(opCode);
  assign fieldOp = (opK == OP_INS) || (opK == OP_CLR) ||
                   (opK == OP_SEXT) || (opK == OP_UEXT);
  assign spanEnd = SUM_W'(lsbPos) + SUM_W'(fieldWidth);
  assign badSpan = fieldOp &&
                   ((fieldWidth == '0) || (spanEnd > SUM_W'(DATA_W)));

  always_comb begin
    ctl          = '0;
    ctl.load     = inValid;
    ctl.rangeBad = badSpan;
    if (badSpan) begin
      ctl.passDst = 1'b1;
    end else begin
      unique case (opK)
        OP_INS:   ctl.selIns  = 1'b1;
        OP_CLR:   ctl.selClr  = 1'b1;
        OP_SEXT:  ctl.selSext = 1'b1;
        OP_UEXT:  ctl.selUext = 1'b1;
        OP_REV:   ctl.selRev  = 1'b1;
        OP_MOVLO: ctl.selLo   = 1'b1;
        OP_MOVHI: ctl.selHi   = 1'b1;
        default:  ctl.passDst = 1'b1;
      endcase
    end
  end

  // R10: every request picks exactly one result path
  a_r10_one_path: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> ($countones({ctl.selIns, ctl.selClr, ctl.selSext, ctl.selUext,
                              ctl.selRev, ctl.selLo, ctl.selHi, ctl.passDst}) == 1));

  // R11: codes above the field group never raise the range error
  a_r11_no_err_nonfield: assert property (@(posedge clk) disable iff (!rstN)
    (opCode[2] == 1'b1) |-> !ctl.rangeBad);

  // R10: a full-width field starting at bit zero is legal
  a_r10_full_width_ok: assert property (@(posedge clk) disable iff (!rstN)
    (!opCode[2] && lsbPos == '0 && fieldWidth == WID_W'(DATA_W)) |-> !ctl.rangeBad);

endmodule

// File: rtl/bfa_datapath.sv
module bfa_datapath #(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  bfa_pkg::strobes_t            ctl,
  input  logic [DATA_W-1:0]            dstVal,
  input  logic [DATA_W-1:0]            srcVal,
  input  logic [DATA_W/2-1:0]          immVal,
  input  logic [$clog2(DATA_W)-1:0]    lsbPos,
  input  logic [$clog2(DATA_W):0]      fieldWidth,
  output logic                         outValid,
  output logic [DATA_W-1:0]            result,
  output logic                         rangeErr
);
  localparam int HALF_W = DATA_W / 2;
  localparam int POS_W  = $clog2(DATA_W);
  localparam int WID_W  = POS_W + 1;

  logic [DATA_W-1:0] lowMask;
  logic [DATA_W-1:0] fieldMask;
  logic [DATA_W-1:0] insVal;
  logic [DATA_W-1:0] clrVal;
  logic [DATA_W-1:0] rawSlice;
  logic [DATA_W-1:0] uextVal;
  logic [DATA_W-1:0] sextVal;
  logic [DATA_W-1:0] revVal;
  logic [DATA_W-1:0] loVal;
  logic [DATA_W-1:0] hiVal;
  logic [DATA_W-1:0] nextVal;
  logic [POS_W-1:0]  topIdx;
  logic              signBit;

  // Low mask of 'width' ones; full width handled apart to avoid shift overflow.
  always_comb begin
    if (fieldWidth >= WID_W'(DATA_W)) lowMask = '1;
    else lowMask = (DATA_W'(1) << fieldWidth) - DATA_W'(1);
  end

  assign fieldMask = lowMask << lsbPos;
  assign insVal    = (dstVal & ~fieldMask) | ((srcVal << lsbPos) & fieldMask);
  assign clrVal    = dstVal & ~fieldMask;

  assign rawSlice  = srcVal >> lsbPos;
  assign topIdx    = POS_W'(fieldWidth - WID_W'(1));
  assign signBit   = rawSlice[topIdx];
  assign uextVal   = rawSlice & lowMask;
  assign sextVal   = uextVal | (signBit ? ~lowMask : '0);

  for (genvar k = 0; k < DATA_W; k++) begin : g_rev
    assign revVal[k] = srcVal[DATA_W-1-k];
  end

  assign loVal = {{HALF_W{1'b0}}, immVal};
  assign hiVal = {immVal, dstVal[HALF_W-1:0]};

  always_comb begin
    nextVal = dstVal;
    if (ctl.selIns)  nextVal = insVal;
    if (ctl.selClr)  nextVal = clrVal;
    if (ctl.selSext) nextVal = sextVal;
    if (ctl.selUext) nextVal = uextVal;
    if (ctl.selRev)  nextVal = revVal;
    if (ctl.selLo)   nextVal = loVal;
    if (ctl.selHi)   nextVal = hiVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      rangeErr <= 1'b0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) begin
        result   <= nextVal;
        rangeErr <= ctl.rangeBad;
      end
    end
  end

  // R2: valid follows the request one edge later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> outValid);

  // R2: idle edges hold the result
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> (!outValid && $stable(result) && $stable(rangeErr)));

  // R3: low constant leaves the upper half zero
  a_r3_lo_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.selLo) |=> (result[DATA_W-1:HALF_W] == '0));

  // R4: high constant keeps the destination's low half
  a_r4_hi_keeps_low: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.selHi) |=> (result[HALF_W-1:0] == $past(dstVal[HALF_W-1:0])));

  // R6: cleared field reads zero
  a_r6_clr_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.selClr) |=> ((result & $past(fieldMask)) == '0));

  // R9: top source bit lands in result bit zero
  a_r9_rev_end: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.selRev) |=> (result[0] == $past(srcVal[DATA_W-1])));

  // R10: rejected or reserved requests return the destination
  a_r10_pass_dst: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.passDst) |=> (result == $past(dstVal)));

endmodule

// File: rtl/bitfield_alu.sv
module bitfield_alu #(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [2:0]                   opCode,
  input  logic [DATA_W-1:0]            dstVal,
  input  logic [DATA_W-1:0]            srcVal,
  input  logic [DATA_W/2-1:0]          immVal,
  input  logic [$clog2(DATA_W)-1:0]    lsbPos,
  input  logic [$clog2(DATA_W):0]      fieldWidth,
  output logic                         outValid,
  output logic [DATA_W-1:0]            result,
  output logic                         rangeErr
);
  bfa_pkg::strobes_t ctl;

  bfa_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .opCode     (opCode),
    .lsbPos     (lsbPos),
    .fieldWidth (fieldWidth),
    .ctl        (ctl)
  );

  bfa_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .dstVal     (dstVal),
    .srcVal     (srcVal),
    .immVal     (immVal),
    .lsbPos     (lsbPos),
    .fieldWidth (fieldWidth),
    .outValid   (outValid),
    .result     (result),
    .rangeErr   (rangeErr)
  );

endmodule

// File: tb/test_bitfield_alu.sv
module test_bitfield_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] dstVal = '0;
  logic [31:0] srcVal = '0;
  logic [15:0] immVal = '0;
  logic [4:0]  lsbPos = '0;
  logic [5:0]  fieldWidth = '0;
  logic        outValid;
  logic [31:0] result;
  logic        rangeErr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_alu i_bitfield_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .dstVal(dstVal), .srcVal(srcVal), .immVal(immVal), .lsbPos(lsbPos),
    .fieldWidth(fieldWidth), .outValid(outValid), .result(result),
    .rangeErr(rangeErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-by-bit model written from the requirement text.
  task automatic model(input int op, input logic [31:0] d, input logic [31:0] s,
                       input logic [15:0] im, input int lsb, input int wid,
                       output logic [31:0] r, output logic e);
    e = 1'b0;
    r = d;
    if (op <= 3 && (wid < 1 || wid > 32 || lsb + wid > 32)) begin
      e = 1'b1;
      return;
    end
    case (op)
      0: for (int k = lsb; k < lsb + wid; k++) r[k] = s[k - lsb];
      1: for (int k = lsb; k < lsb + wid; k++) r[k] = 1'b0;
      2, 3: begin
        for (int k = 0; k < 32; k++)
          r[k] = (k < wid) ? s[lsb + k] : ((op == 2) ? s[lsb + wid - 1] : 1'b0);
      end
      4: for (int k = 0; k < 32; k++) r[k] = s[31 - k];
      5: r = {16'h0000, im};
      6: r = {im, d[15:0]};
      default: r = d;
    endcase
  endtask

  task automatic runOp(input string req, input int op, input logic [31:0] d,
                       input logic [31:0] s, input logic [15:0] im,
                       input int lsb, input int wid);
    logic [31:0] er;
    logic        ee;
    model(op, d, s, im, lsb, wid, er, ee);
    @(negedge clk);
    inValid = 1'b1; opCode = 3'(op); dstVal = d; srcVal = s; immVal = im;
    lsbPos = 5'(lsb); fieldWidth = 6'(wid);
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, {31'b0, outValid}, 32'd1);
    check({req, " result"}, result, er);
    check({req, " rangeErr"}, {31'b0, rangeErr}, {31'b0, ee});
  endtask

  task automatic t_reset;
    check("R1 outValid", {31'b0, outValid}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 rangeErr", {31'b0, rangeErr}, 32'd0);
  endtask

  task automatic t_moves;
    runOp("R3 lo", 5, 32'hDEAD_BEEF, 32'h0, 16'h8001, 0, 0);
    runOp("R3 lo bad width ignored", 5, 32'h1234_5678, 32'h0, 16'hFFFF, 31, 40);
    runOp("R4 hi", 6, 32'hCAFE_F00D, 32'h0, 16'h1357, 0, 0);
    runOp("R4 hi keeps low", 6, 32'h0000_ABCD, 32'hFFFF_FFFF, 16'hFFFF, 7, 0);
  endtask

  task automatic t_insert;
    runOp("R5 mid", 0, 32'hFFFF_FFFF, 32'h0000_0005, 16'h0, 8, 4);
    runOp("R5 full", 0, 32'h1234_5678, 32'h89AB_CDEF, 16'h0, 0, 32);
    runOp("R5 top bit", 0, 32'h0000_0000, 32'hFFFF_FFFF, 16'h0, 31, 1);
    runOp("R5 ends at 31", 0, 32'hA5A5_A5A5, 32'h0000_0F0F, 16'h0, 20, 12);
  endtask

  task automatic t_clear;
    runOp("R6 mid", 1, 32'hFFFF_FFFF, 32'h0, 16'h0, 4, 8);
    runOp("R6 full", 1, 32'h8765_4321, 32'h0, 16'h0, 0, 32);
    runOp("R6 bit0", 1, 32'h0000_0003, 32'h0, 16'h0, 0, 1);
  endtask

  task automatic t_extract;
    runOp("R7 neg", 2, 32'h0, 32'h0000_0F00, 16'h0, 8, 4);
    runOp("R7 pos", 2, 32'h0, 32'h0000_0700, 16'h0, 8, 4);
    runOp("R7 top field", 2, 32'h0, 32'h8000_0000, 16'h0, 28, 4);
    runOp("R7 full", 2, 32'h0, 32'h9000_0001, 16'h0, 0, 32);
    runOp("R8 neg pattern", 3, 32'hFFFF_FFFF, 32'h0000_0F00, 16'h0, 8, 4);
    runOp("R8 one bit 31", 3, 32'h0, 32'h8000_0000, 16'h0, 31, 1);
  endtask

  task automatic t_reverse;
    runOp("R9 one", 4, 32'h0, 32'h0000_0001, 16'h0, 0, 0);
    runOp("R9 mixed", 4, 32'h0, 32'h1234_5678, 16'h0, 3, 50);
  endtask

  task automatic t_range;
    runOp("R10 span 33", 0, 32'h0BAD_F00D, 32'hFFFF_FFFF, 16'h0, 30, 3);
    runOp("R10 width 0", 1, 32'h7777_7777, 32'h0, 16'h0, 4, 0);
    runOp("R10 width 33", 3, 32'h3333_3333, 32'hFFFF_FFFF, 16'h0, 0, 33);
    runOp("R10 sext span", 2, 32'h5555_AAAA, 32'hFFFF_FFFF, 16'h0, 16, 17);
    runOp("R10 legal after err", 3, 32'h0, 32'hF000_0000, 16'h0, 28, 4);
  endtask

  task automatic t_reserved;
    runOp("R11 rsvd", 7, 32'hFACE_B00C, 32'h1111_1111, 16'h2222, 30, 60);
  endtask

  task automatic t_hold;
    logic [31:0] keep;
    runOp("R2 setup", 5, 32'h0, 32'h0, 16'h4242, 0, 0);
    keep = result;
    @(negedge clk);
    dstVal = 32'hFFFF_FFFF; immVal = 16'h9999; opCode = 3'd5;
    @(negedge clk);
    check("R2 idle valid", {31'b0, outValid}, 32'd0);
    check("R2 idle hold", result, keep);
    check("R2 idle err", {31'b0, rangeErr}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset;
    @(negedge clk);
    rstN = 1'b1;
    t_moves;
    t_insert;
    t_clear;
    t_extract;
    t_reverse;
    t_range;
    t_reserved;
    t_hold;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule